// File: doc/BRIEF.md
# Stepped Memory Port with Auto-Repeat

This block gives a host CPU a byte-wide window into a local memory. The host loads a 16-bit pointer as two byte registers and sets a signed 8-bit step. Every access through the data register goes to the memory location at the pointer. After that access, the step is sign-extended and added to the pointer, and the pointer wraps modulo 65536. A data write stores its byte in memory. A data read returns the byte at the pointer, but only when the shared read-enable input is high.

Writing a count N to the repeat register makes the port replay its most recent data write N more times, at one memory write per clock. The pointer steps after each of those writes. A count of zero requests 256 replays. While a replay runs, the host can poll the repeat register to see how many writes are left. An external sequencer can instead stall on the `busy` output. The port issues at most one memory request in any cycle. The memory is assumed to return read data in the same cycle as the request.

Top module: `stepped_mem_port`

## Requirements
- R1: After reset the pointer, step, stored data byte and repeat count are all zero, and `busy` is low.
- R2: Register indices on `reg_sel` are 0 pointer low byte, 1 pointer high byte, 2 step, 3 data, 4 repeat. Writes to indices 0 and 1 set the matching pointer byte, and reads of indices 0, 1 and 2 return the stored values.
- R3: A host write to the data register writes that byte to memory at the pointer in the same cycle. On the next clock the pointer becomes the pointer plus the sign-extended step, modulo 65536.
- R4: The step is a two's complement value from -128 to +127, so step 0xFD moves the pointer down by 3 and can cross from 0x0000 to 0xFFFF.
- R5: Writing N (1 to 255) to the repeat register while idle makes N further memory writes of the last data-register byte, one per clock. These start on the clock after the repeat write, and each one steps the pointer.
- R6: Writing 0 to the repeat register starts 256 replays. While the remaining count is 256, the repeat register reads 0xFF.
- R7: A read of the repeat register returns the number of replays still pending. It reads 0 only when the port is idle.
- R8: `busy` is high exactly while replays are pending, and every such cycle carries a memory write request.
- R9: A write to the repeat register while `busy` is high is ignored, and the running count is not changed.
- R10: With `rd_enable` high and the port idle, a read of the data register returns the memory byte at the pointer and then steps the pointer. With `rd_enable` low, such a read returns 0, makes no memory request and leaves the pointer alone.
- R11: While `busy` is high, a host write to the data register makes no extra memory access and does not change the replayed byte.
- R12: While `busy` is high, writes to the pointer and step registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of `reg_rd` |
| rd_enable | input | 1 | Shared control bit that allows data-register reads |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle as the request |
| busy | output | 1 | Replay in progress |

## Verification
The hardest case to reach is a count of exactly 256. The port holds that value for only one cycle, right after the repeat write, so a poll must land in that exact cycle to catch the 0xFF readback. The bench reads the repeat register in the cycle that follows the zero write. It then counts the remaining busy cycles and checks that the final pointer has moved by 257, which covers the original write plus 256 replays. The cases where writes must be ignored are reached by issuing repeat, data, pointer and step writes inside a running replay. The bench then checks the memory contents and the final pointer to show that none of those writes took effect.

// File: rtl/smp_pkg.sv
// Package: shared register indices for the stepped memory port.
// Assumes a 3-bit register index bus.
package smp_pkg;
    typedef enum logic [2:0] {
        REG_ADDR_LO = 3'd0,
        REG_ADDR_HI = 3'd1,
        REG_STEP    = 3'd2,
        REG_DATA    = 3'd3,
        REG_REPEAT  = 3'd4
    } smp_reg_e;
endpackage

// File: rtl/smp_decode.sv
// Module: turns a host register access into single-purpose strobes.
// Assumes write wins over read when both strobes are high. Every
// strobe is suppressed while a replay runs, which keeps the port to
// one memory access per cycle.
module smp_decode
    import smp_pkg::*;
(
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_sel,
    input  logic       rd_enable,
    input  logic       busy,
    output logic       ld_lo,
    output logic       ld_hi,
    output logic       ld_step,
    output logic       ld_data,
    output logic       start_rep,
    output logic       host_rd
);
    logic wr_ok;
    logic rd_ok;

    // Gate host strobes by the replay state.
    always_comb begin
        wr_ok     = reg_wr && !busy;
        rd_ok     = reg_rd && !reg_wr && !busy;
        ld_lo     = wr_ok && (reg_sel == REG_ADDR_LO);
        ld_hi     = wr_ok && (reg_sel == REG_ADDR_HI);
        ld_step   = wr_ok && (reg_sel == REG_STEP);
        ld_data   = wr_ok && (reg_sel == REG_DATA);
        start_rep = wr_ok && (reg_sel == REG_REPEAT);
        host_rd   = rd_ok && rd_enable && (reg_sel == REG_DATA);
    end
endmodule

// File: rtl/smp_pointer.sv
// Module: holds the address pointer and the signed step.
// Assumes DATA_W < ADDR_W <= 2*DATA_W. An access (advance) has priority
// over a byte load; the decoder never asserts both together.
module smp_pointer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              ld_step,
    input  logic              advance,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] step
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int EXT_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] step_ext;

    // Sign-extend the step to pointer width.
    always_comb step_ext = {{EXT_W{step[DATA_W-1]}}, step};

    // Update the step register.
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= '0;
        else if (ld_step) step <= wdata;
    end

    // Step the pointer after an access, or load one of its bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (advance) ptr <= ptr + step_ext;
        else if (ld_lo)   ptr[DATA_W-1:0] <= wdata;
        else if (ld_hi)   ptr[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
    end
endmodule

// File: rtl/smp_repeat.sv
// Module: replay counter. A load of zero means 2**DATA_W replays. The
// counter is one bit wider than the data path. Readback saturates to
// all ones at the full count, so it reads zero only when idle.
// Assumes start is raised only while idle.
module smp_repeat #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_val,
    output logic              busy,
    output logic [DATA_W:0]   cnt,
    output logic [DATA_W-1:0] readback
);
    localparam int CNT_W = DATA_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << DATA_W;

    // Load on start, otherwise count one replay per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= (start_val == '0) ? FULL : {1'b0, start_val};
        else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
    end

    // Derive busy and the host-visible remaining count.
    always_comb begin
        busy     = (cnt != '0);
        readback = cnt[DATA_W] ? '1 : cnt[DATA_W-1:0];
    end
endmodule

// File: rtl/stepped_mem_port.sv
// Module: host-visible stepped memory port with hardware write replay.
// Assumes a memory that returns read data in the request cycle and
// accepts one request per cycle. Replays own the memory request path
// while busy.
module stepped_mem_port
    import smp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rd_enable,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic              ld_lo, ld_hi, ld_step, ld_data, start_rep, host_rd;
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] step_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W:0]   rep_cnt;
    logic [DATA_W-1:0] rep_rb;
    logic [DATA_W-1:0] hi_rb;

    smp_decode u_dec (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .rd_enable (rd_enable),
        .busy      (busy),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .ld_step   (ld_step),
        .ld_data   (ld_data),
        .start_rep (start_rep),
        .host_rd   (host_rd)
    );

    smp_pointer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_step (ld_step),
        .advance (mem_req),
        .wdata   (reg_wdata),
        .ptr     (ptr_q),
        .step    (step_q)
    );

    smp_repeat #(.DATA_W(DATA_W)) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_rep),
        .start_val (reg_wdata),
        .busy      (busy),
        .cnt       (rep_cnt),
        .readback  (rep_rb)
    );

    // Remember the last host data write for replay.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (ld_data) data_q <= reg_wdata;
    end

    // Drive the single memory request: replay, host write or host read.
    always_comb begin
        mem_req   = busy || ld_data || host_rd;
        mem_we    = busy || ld_data;
        mem_addr  = ptr_q;
        mem_wdata = busy ? data_q : reg_wdata;
    end

    // Zero-extend the pointer high byte for readback.
    always_comb begin
        hi_rb           = '0;
        hi_rb[HI_W-1:0] = ptr_q[ADDR_W-1:DATA_W];
    end

    // Select register readback data.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_sel)
                REG_ADDR_LO: reg_rdata = ptr_q[DATA_W-1:0];
                REG_ADDR_HI: reg_rdata = hi_rb;
                REG_STEP:    reg_rdata = step_q;
                REG_DATA:    reg_rdata = host_rd ? mem_rdata : '0;
                REG_REPEAT:  reg_rdata = rep_rb;
                default:     reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/stepped_mem_port_chk.sv
// Checker: temporal properties of the stepped memory port, bound to
// the top module.
module smp_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] step,
    input logic [DATA_W:0]   cnt,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              rd_enable
);
    localparam int EXT_W = ADDR_W - DATA_W;
    localparam logic [DATA_W:0] FULL = (DATA_W+1)'(1) << DATA_W;

    logic [ADDR_W-1:0] step_x;
    always_comb step_x = {{EXT_W{step[DATA_W-1]}}, step};

    // R8: every busy cycle issues a memory write
    p_busy_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_req && mem_we));

    // R5: replayed byte stays constant through a replay
    p_replay_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mem_wdata == $past(mem_wdata)));

    // R3: consecutive replay addresses differ by the sign-extended step
    p_replay_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mem_addr == $past(mem_addr) + step_x));

    // R7: the pending count drops by one per busy cycle
    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> (cnt == $past(cnt) - 1'b1));

    // R6: the count never exceeds the full-scale value
    p_cnt_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    // R7: repeat readback is zero exactly when idle
    p_idle_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_sel == 3'd4) |-> ((reg_rdata == '0) == !busy));

    // R10: no memory request without a cause
    p_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !reg_wr && !(reg_rd && rd_enable)) |-> !mem_req);
endmodule

bind stepped_mem_port smp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .step      (step_q),
    .cnt       (rep_cnt),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .rd_enable (rd_enable)
);

// File: tb/test_stepped_mem_port.sv
`timescale 1ns/1ps
module test_stepped_mem_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        rd_enable = 1'b0;
    logic        mem_req, mem_we, busy;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  bmem [0:1023];
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    stepped_mem_port i_stepped_mem_port (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_enable(rd_enable), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy)
    );

    // Bench memory model: low 10 address bits, same-cycle read.
    assign mem_rdata = bmem[mem_addr[9:0]];
    always @(posedge clk) if (mem_req && mem_we) bmem[mem_addr[9:0]] <= mem_wdata;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] s, logic [7:0] v);
        @(negedge clk); reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] s, output logic [7:0] v);
        @(negedge clk); reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic get_ptr(output logic [15:0] p);
        logic [7:0] lo, hi;
        rd(3'd0, lo); rd(3'd1, hi);
        p = {hi, lo};
    endtask

    task automatic set_ptr(logic [15:0] p);
        wr(3'd0, p[7:0]); wr(3'd1, p[15:8]);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 1000) begin @(posedge clk); #1 cyc++; end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd0, v); chk("R1 ptr lo", v, 0);
        rd(3'd1, v); chk("R1 ptr hi", v, 0);
        rd(3'd2, v); chk("R1 step", v, 0);
        rd(3'd4, v); chk("R1 repeat", v, 0);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_ptr_regs();
        logic [15:0] p; logic [7:0] v;
        set_ptr(16'h0234); wr(3'd2, 8'h01);
        get_ptr(p); chk("R2 pointer readback", p, 16'h0234);
        rd(3'd2, v); chk("R2 step readback", v, 8'h01);
    endtask

    task automatic t_single_write();
        logic [15:0] p;
        wr(3'd3, 8'hA5);
        chk("R3 mem byte", bmem[10'h234], 8'hA5);
        get_ptr(p); chk("R3 pointer stepped", p, 16'h0235);
    endtask

    task automatic t_neg_step();
        logic [15:0] p;
        set_ptr(16'h0001); wr(3'd2, 8'hFD);
        wr(3'd3, 8'h11);
        get_ptr(p); chk("R4 wrap below zero", p, 16'hFFFE);
        wr(3'd3, 8'h22);
        chk("R4 byte at 0x0001", bmem[10'h001], 8'h11);
        chk("R4 byte at 0xFFFE", bmem[10'h3FE], 8'h22);
        get_ptr(p); chk("R4 pointer -3", p, 16'hFFFB);
    endtask

    task automatic t_repeat3();
        logic [15:0] p; logic [7:0] v; int c;
        set_ptr(16'h0100); wr(3'd2, 8'h01);
        wr(3'd3, 8'h5A); wr(3'd4, 8'd3);
        chk("R8 busy after start", busy, 1);
        rd(3'd4, v); chk("R7 remaining count", v, 8'd3);
        wait_idle(c);
        rd(3'd4, v); chk("R7 idle reads zero", v, 0);
        for (int i = 0; i < 4; i++) chk("R5 replayed byte", bmem[10'h100 + i], 8'h5A);
        chk("R5 no extra write", bmem[10'h104], 8'h00);
        get_ptr(p); chk("R5 pointer after replay", p, 16'h0104);
    endtask

    task automatic t_repeat256();
        logic [15:0] p; logic [7:0] v; int c;
        set_ptr(16'h0200);
        wr(3'd3, 8'h77); wr(3'd4, 8'd0);
        rd(3'd4, v); chk("R6 full count reads FF", v, 8'hFF);
        wait_idle(c); chk("R8 busy cycles after poll", c, 255);
        get_ptr(p); chk("R6 pointer after 256", p, 16'h0301);
        chk("R6 last replay byte", bmem[10'h300], 8'h77);
        chk("R6 first byte", bmem[10'h200], 8'h77);
    endtask

    task automatic t_repeat_ignored();
        logic [15:0] p; int c;
        set_ptr(16'h0010);
        wr(3'd3, 8'h44); wr(3'd4, 8'd10); wr(3'd4, 8'd200);
        wait_idle(c);
        get_ptr(p); chk("R9 second repeat ignored", p, 16'h001B);
        chk("R9 no write past end", bmem[10'h01B], 8'h00);
    endtask

    task automatic t_regs_locked();
        logic [15:0] p; logic [7:0] v; int c;
        set_ptr(16'h0040);
        wr(3'd3, 8'h66); wr(3'd4, 8'd8);
        wr(3'd0, 8'hF0); wr(3'd2, 8'h05);
        wait_idle(c);
        get_ptr(p); chk("R12 pointer write ignored", p, 16'h0049);
        rd(3'd2, v); chk("R12 step write ignored", v, 8'h01);
    endtask

    task automatic t_data_read();
        logic [15:0] p; logic [7:0] v;
        set_ptr(16'h0100);
        rd_enable = 1'b0;
        rd(3'd3, v); chk("R10 disabled read value", v, 0);
        get_ptr(p); chk("R10 disabled read no step", p, 16'h0100);
        rd_enable = 1'b1;
        rd(3'd3, v); chk("R10 enabled read value", v, 8'h5A);
        get_ptr(p); chk("R10 enabled read steps", p, 16'h0101);
        rd_enable = 1'b0;
    endtask

    task automatic t_data_during_busy();
        logic [15:0] p; int c;
        set_ptr(16'h0380);
        wr(3'd3, 8'h33); wr(3'd4, 8'd6); wr(3'd3, 8'h99);
        wait_idle(c);
        for (int i = 0; i < 7; i++) chk("R11 replay byte kept", bmem[10'h380 + i], 8'h33);
        chk("R11 no extra access", bmem[10'h387], 8'h00);
        get_ptr(p); chk("R11 pointer", p, 16'h0387);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ptr_regs();
        t_single_write();
        t_neg_step();
        t_repeat3();
        t_repeat256();
        t_repeat_ignored();
        t_regs_locked();
        t_data_read();
        t_data_during_busy();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule